// File: doc/BRIEF.md
# Phase Accumulator for a Digital Down-Converter Oscillator

This block produces the running phase of a numerically controlled oscillator inside a down-converter. On every enabled sample the phase grows by an active frequency word and wraps modulo 2^32. A downstream sine/cosine lookup consumes the phase and a valid strobe. The lookup table and the mixer sit outside this block.

Software supplies the 32-bit frequency word one byte at a time into a staging bank. The running frequency does not change on a write. It changes only when software flips a level-type restart control bit. Either direction of that flip counts. In a single step the flip zeroes the phase and copies the staged word into the active slot.

A separate synchronization event also zeroes the phase. Its source is selectable. It can be a register-held level, which software toggles to issue a sync sequence. It can also be a dual-purpose external pin that acts as sync only while a pin-enable bit is set. When that bit is clear, the pin serves as a power-down input.

Top module: `nco_phase_gen`

## Requirements
- R1: While reset is asserted, and until the first event after it, `phase_out` is 0, `phase_vld` is 0 and `pin_pwrdn` is 0.
- R2: A write with `fw_wr`=1 stores `fw_byte` into staged byte `fw_idx` (index 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16, 3 = bits 31:24). Such a write never changes the running frequency. A restart toggle in the same cycle as a write loads the word as it stood before that write.
- R3: In a cycle with `smp_en`=1 and no clear event, `phase_out` after the next clock equals the previous phase plus the active word, modulo 2^32. With `smp_en`=0 and no clear event, the phase holds.
- R4: A restart toggle is a cycle in which `restart_ctl` differs from its value in the previous cycle, where the value during reset counts as 0. Both rising and falling flips count. After the next clock the phase is 0 and the active word equals the staged word.
- R5: With `sync_src_sel`=1, the sync level is `sync_reg_lvl`. A 0-to-1 change of the selected sync level zeroes the phase at the next clock. A level held at 1, and a 1-to-0 change, clear nothing.
- R6: With `sync_src_sel`=0, the sync level is the pin after a two-flop synchronizer, and only while `pin_is_sync`=1. A pin rise that is set up before clock edge k clears the phase at edge k+2. While `pin_is_sync`=0 the pin causes no clear, and `pin_pwrdn` shows the synchronized pin.
- R7: After a clock, `phase_vld` is 1 exactly when the cycle before that clock had `smp_en`=1 or a clear event.
- R8: A clear event in a cycle with `smp_en`=1 yields phase 0, not an added step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en | input | 1 | Sample enable; advance the phase this cycle |
| fw_wr | input | 1 | Frequency byte write strobe |
| fw_idx | input | 2 | Byte index of the write, 0 = least significant |
| fw_byte | input | 8 | Byte value to stage |
| restart_ctl | input | 1 | Level restart control; any flip restarts and loads |
| sync_src_sel | input | 1 | Sync source: 0 = pin, 1 = register level |
| sync_reg_lvl | input | 1 | Register-held sync level |
| pin_is_sync | input | 1 | 1 = dual-purpose pin acts as sync, 0 = power-down |
| sync_pin | input | 1 | Asynchronous dual-purpose pin |
| phase_out | output | 32 | Accumulated phase |
| phase_vld | output | 1 | New phase value present |
| pin_pwrdn | output | 1 | Synchronized pin as power-down request |

## Verification
On every cycle the assertions check the following. A restart flip or a register-sourced sync rise leaves a zero phase. Clear wins over a sample step. An idle cycle keeps the phase and drops the valid strobe. The power-down output stays low while the pin is in sync mode. The bench's scenarios must show everything that depends on the staged word. This covers sums and wraparound, byte placement, and a write that does not reach the running frequency. The scenarios also show the two-cycle pin latency, because the checker cannot see those values.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic {
    SYNC_FROM_PIN = 1'b0,
    SYNC_FROM_REG = 1'b1
  } sync_src_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nco_fcw_bank.sv
module nco_fcw_bank #(
  parameter int unsigned FCW_W  = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              load,
  output logic [FCW_W-1:0]  active_o
);
  localparam int unsigned NBYTES = FCW_W / BYTE_W;

  logic [FCW_W-1:0] staged_q;
  logic [FCW_W-1:0] active_q, active_nx;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_nx;
    always_comb begin
      lane_nx = staged_q[g*BYTE_W +: BYTE_W];
      if (wr_en && (wr_idx == IDX_W'(g))) lane_nx = wr_byte;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) staged_q[g*BYTE_W +: BYTE_W] <= '0;
      else        staged_q[g*BYTE_W +: BYTE_W] <= lane_nx;
    end
  end

  always_comb begin
    active_nx = active_q;
    if (load) active_nx = staged_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active_nx;
  end

  assign active_o = active_q;
endmodule

// File: rtl/nco_event_ctl.sv
module nco_event_ctl
  import nco_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_lvl,
  input  logic src_sel,
  input  logic reg_sync_lvl,
  input  logic pin_sync_en,
  input  logic pin_async,
  output logic restart_o,
  output logic sync_o,
  output logic pwrdn_o
);
  logic [SYNC_STAGES-1:0] pin_pipe_q, pin_pipe_nx;
  logic                   restart_q, restart_nx;
  logic                   sel_q, sel_nx;
  logic                   pin_lvl;
  logic                   sel_lvl;

  always_comb begin
    pin_pipe_nx = {pin_pipe_q[SYNC_STAGES-2:0], pin_async};
  end

  assign pin_lvl = pin_pipe_q[SYNC_STAGES-1];

  always_comb begin
    if (sync_src_e'(src_sel) == SYNC_FROM_REG) sel_lvl = reg_sync_lvl;
    else                                       sel_lvl = pin_sync_en & pin_lvl;
  end

  always_comb begin
    restart_nx = restart_lvl;
    sel_nx     = sel_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_pipe_q <= '0;
      restart_q  <= 1'b0;
      sel_q      <= 1'b0;
    end else begin
      pin_pipe_q <= pin_pipe_nx;
      restart_q  <= restart_nx;
      sel_q      <= sel_nx;
    end
  end

  assign restart_o = restart_lvl ^ restart_q;
  assign sync_o    = sel_lvl & ~sel_q;
  assign pwrdn_o   = ~pin_sync_en & pin_lvl;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned FCW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             clear,
  input  logic [FCW_W-1:0] inc,
  output logic [FCW_W-1:0] phase_o,
  output logic             vld_o
);
  logic [FCW_W-1:0] phase_q, phase_nx;
  logic             vld_q, vld_nx;

  always_comb begin
    phase_nx = phase_q;
    if (clear)        phase_nx = '0;
    else if (step_en) phase_nx = phase_q + inc;
    vld_nx = clear | step_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      vld_q   <= vld_nx;
    end
  end

  assign phase_o = phase_q;
  assign vld_o   = vld_q;
endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
  import nco_pkg::*;
#(
  parameter int unsigned FCW_W       = 32,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     smp_en,
  input  logic                                     fw_wr,
  input  logic [idx_width(FCW_W/BYTE_W)-1:0]       fw_idx,
  input  logic [BYTE_W-1:0]                        fw_byte,
  input  logic                                     restart_ctl,
  input  logic                                     sync_src_sel,
  input  logic                                     sync_reg_lvl,
  input  logic                                     pin_is_sync,
  input  logic                                     sync_pin,
  output logic [FCW_W-1:0]                         phase_out,
  output logic                                     phase_vld,
  output logic                                     pin_pwrdn
);
  localparam int unsigned IDX_W = idx_width(FCW_W / BYTE_W);

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic             restart_evt;
  logic             sync_evt;
  logic [FCW_W-1:0] active_fcw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  nco_event_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .restart_lvl (restart_ctl),
    .src_sel     (sync_src_sel),
    .reg_sync_lvl(sync_reg_lvl),
    .pin_sync_en (pin_is_sync),
    .pin_async   (sync_pin),
    .restart_o   (restart_evt),
    .sync_o      (sync_evt),
    .pwrdn_o     (pin_pwrdn)
  );

  nco_fcw_bank #(.FCW_W(FCW_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_fcw (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (fw_wr),
    .wr_idx  (fw_idx),
    .wr_byte (fw_byte),
    .load    (restart_evt),
    .active_o(active_fcw)
  );

  nco_phase_acc #(.FCW_W(FCW_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .step_en(smp_en),
    .clear  (restart_evt | sync_evt),
    .inc    (active_fcw),
    .phase_o(phase_out),
    .vld_o  (phase_vld)
  );
endmodule

// File: rtl/nco_phase_gen_chk.sv
module nco_phase_gen_chk #(
  parameter int unsigned FCW_W = 32
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             smp_en,
  input logic             restart_ctl,
  input logic             sync_src_sel,
  input logic             sync_reg_lvl,
  input logic             pin_is_sync,
  input logic [FCW_W-1:0] phase_out,
  input logic             phase_vld,
  input logic             pin_pwrdn
);
  logic rc_q;
  logic prev_src_reg_q;
  logic prev_lvl_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rc_q           <= 1'b0;
      prev_src_reg_q <= 1'b0;
      prev_lvl_q     <= 1'b0;
    end else begin
      rc_q           <= restart_ctl;
      prev_src_reg_q <= sync_src_sel;
      prev_lvl_q     <= sync_reg_lvl;
    end
  end

  logic quiet;
  assign quiet = (restart_ctl == rc_q) && sync_src_sel && !sync_reg_lvl;

  a_r4_toggle_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    (restart_ctl != rc_q) |=> (phase_out == '0));

  a_r5_reg_rise_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sync_src_sel && sync_reg_lvl && prev_src_reg_q && !prev_lvl_q) |=> (phase_out == '0));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!smp_en && quiet) |=> $stable(phase_out));

  a_r7_vld_on_step: assert property (@(posedge clk) disable iff (!rst_core_n)
    smp_en |=> phase_vld);

  a_r7_vld_idle_low: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!smp_en && quiet) |=> !phase_vld);

  a_r8_clear_over_step: assert property (@(posedge clk) disable iff (!rst_core_n)
    (smp_en && restart_ctl != rc_q) |=> (phase_out == '0));

  a_r6_pwrdn_masked: assert property (@(posedge clk) disable iff (!rst_core_n)
    pin_is_sync |-> !pin_pwrdn);
endmodule

bind nco_phase_gen nco_phase_gen_chk #(.FCW_W(FCW_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .smp_en      (smp_en),
  .restart_ctl (restart_ctl),
  .sync_src_sel(sync_src_sel),
  .sync_reg_lvl(sync_reg_lvl),
  .pin_is_sync (pin_is_sync),
  .phase_out   (phase_out),
  .phase_vld   (phase_vld),
  .pin_pwrdn   (pin_pwrdn)
);

// File: tb/sim_nco_phase_gen.sv
`timescale 1ns/1ps
module sim_nco_phase_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_en, fw_wr, restart_ctl, sync_src_sel, sync_reg_lvl, pin_is_sync, sync_pin;
  logic [1:0]  fw_idx;
  logic [7:0]  fw_byte;
  logic [31:0] phase_out;
  logic        phase_vld, pin_pwrdn;

  int errs = 0;
  int chks = 0;
  bit done = 0;

  logic [31:0] m_phase, m_act, m_stg;
  logic        m_vld, m_s1, m_s2, m_sel, m_rc;

  always #4 clk = ~clk;

  nco_phase_gen u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .fw_wr(fw_wr), .fw_idx(fw_idx),
    .fw_byte(fw_byte), .restart_ctl(restart_ctl), .sync_src_sel(sync_src_sel),
    .sync_reg_lvl(sync_reg_lvl), .pin_is_sync(pin_is_sync), .sync_pin(sync_pin),
    .phase_out(phase_out), .phase_vld(phase_vld), .pin_pwrdn(pin_pwrdn)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    chks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  // one clock: model the requirements at the edge, compare at the falling edge
  task automatic tick(input string tag);
    logic tog, sel, rise, clr;
    @(posedge clk);
    tog  = (restart_ctl != m_rc);
    sel  = sync_src_sel ? sync_reg_lvl : (pin_is_sync & m_s2);
    rise = sel & ~m_sel;
    clr  = tog | rise;
    if (clr)         m_phase = 32'h0;
    else if (smp_en) m_phase = m_phase + m_act;
    if (tog) m_act = m_stg;
    if (fw_wr) m_stg[fw_idx*8 +: 8] = fw_byte;
    m_vld = smp_en | clr;
    m_s2 = m_s1; m_s1 = sync_pin; m_sel = sel; m_rc = restart_ctl;
    @(negedge clk);
    check(tag, "phase", phase_out, m_phase);
    check("R7", "vld", {31'h0, phase_vld}, {31'h0, m_vld});
    check("R6", "pwrdn", {31'h0, pin_pwrdn}, {31'h0, ~pin_is_sync & m_s2});
  endtask

  task automatic write_word(input logic [31:0] w, input string tag);
    for (int b = 0; b < 4; b++) begin
      fw_wr = 1'b1; fw_idx = 2'(b); fw_byte = w[b*8 +: 8];
      tick(tag);
    end
    fw_wr = 1'b0;
  endtask

  function automatic logic [31:0] lfsr(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog expired got running exp finished");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; smp_en = 0; fw_wr = 0; fw_idx = 0; fw_byte = 0;
    restart_ctl = 0; sync_src_sel = 1; sync_reg_lvl = 0; pin_is_sync = 0; sync_pin = 0;
    m_phase = 0; m_act = 0; m_stg = 0; m_vld = 0; m_s1 = 0; m_s2 = 0; m_sel = 0; m_rc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "phase", phase_out, 32'h0);
    check("R1", "vld", {31'h0, phase_vld}, 32'h0);
    check("R1", "pwrdn", {31'h0, pin_pwrdn}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "phase after release", phase_out, 32'h0);

    // R2: staged bytes do not reach the running frequency
    smp_en = 1'b1;
    write_word(32'h0102_0304, "R2");
    check("R2", "phase before toggle", phase_out, 32'h0);
    // R4: rising toggle loads and restarts
    restart_ctl = 1'b1; tick("R4");
    check("R4", "phase at toggle", phase_out, 32'h0);
    tick("R4");
    check("R4", "first step", phase_out, 32'h0102_0304);
    repeat (3) tick("R3");
    // R2: new word staged, old one keeps running
    write_word(32'hA0B0_C0D0, "R2");
    tick("R2");
    check("R2", "old word runs", phase_out, 32'h0102_0304 * 9);
    // R4: falling toggle also loads
    restart_ctl = 1'b0; tick("R4");
    tick("R4");
    check("R4", "falling toggle word", phase_out, 32'hA0B0_C0D0);
    // R2: toggle in the same cycle as a write loads the prior word
    fw_wr = 1; fw_idx = 0; fw_byte = 8'h55; restart_ctl = 1'b1; tick("R2");
    fw_wr = 0; tick("R2");
    check("R2", "same-cycle write excluded", phase_out, 32'hA0B0_C0D0);

    // R3 sweep: many words, gated sample patterns, wraparound
    seed = 32'h1357_9BDF;
    for (int k = 0; k < 24; k++) begin
      logic [31:0] w;
      w = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h8000_0000 : (k == 2) ? 32'h0000_0001 : seed;
      seed = lfsr(seed);
      smp_en = 1'b0;
      write_word(w, "R3");
      restart_ctl = ~restart_ctl; tick("R4");
      for (int i = 0; i < 40; i++) begin
        smp_en = ((i + k) % 3) != 2;
        tick("R3");
      end
      // R8: toggle during a sample step wins
      smp_en = 1'b1; restart_ctl = ~restart_ctl; tick("R8");
      check("R8", "clear over step", phase_out, 32'h0);
      tick("R3");
    end

    // R5: register-held sync level
    smp_en = 1'b1; sync_src_sel = 1'b1;
    repeat (5) tick("R3");
    sync_reg_lvl = 1'b1; tick("R5");
    check("R5", "rise clears", phase_out, 32'h0);
    repeat (4) tick("R5");
    check("R5", "held level no clear", phase_out, m_act * 4);
    sync_reg_lvl = 1'b0; repeat (2) tick("R5");
    sync_reg_lvl = 1'b1; tick("R5");
    check("R5", "second rise clears", phase_out, 32'h0);
    sync_reg_lvl = 1'b0; tick("R5");

    // R6: pin as sync source, two-flop latency
    sync_src_sel = 1'b0; pin_is_sync = 1'b1;
    repeat (3) tick("R6");
    sync_pin = 1'b1; tick("R6"); tick("R6");
    check("R6", "not yet cleared", phase_out, m_phase);
    tick("R6");
    check("R6", "pin rise clears at k+2", phase_out, 32'h0);
    repeat (3) tick("R6");
    sync_pin = 1'b0; repeat (4) tick("R6");
    // R6: pin as power-down, no clears
    pin_is_sync = 1'b0;
    for (int i = 0; i < 24; i++) begin
      sync_pin = i[2];
      smp_en = i[0];
      tick("R6");
    end
    // R5: register level ignored while the pin is selected
    sync_reg_lvl = 1'b1; repeat (3) tick("R5");
    sync_reg_lvl = 1'b0; smp_en = 1'b0; repeat (2) tick("R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule